// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

An 8-pin general-purpose I/O port with a small register bus. Software sets each pin's direction and output value, reads back the level at the pad, and arms per-pin edge interrupts. On the pad side, each pin gets an output enable, an output value and a weak-pullup enable. When a pin is an input, its output-data bit does double duty as the pullup control. A per-pin override lets a peripheral such as a PWM unit drive the pad instead of the port registers.

Pad inputs pass through a two-flop synchronizer. The synchronized value feeds the input register and an edge detector. The detector compares the synchronized level with its value one cycle earlier. Interrupt flags latch on the selected edge in every pin mode and stay set until software clears them. A parameter selects a 7-pin build. In that build bit 7 is absent, and while the debug-port input is high the GPIO function is disabled and the low four pins belong to the debug port.

Register map (3-bit address, combinational read, write on the clock edge when `bus_we` is 1): 0 direction, 1 output data, 2 input level (read-only), 3 interrupt flags, 4 interrupt enables, 5 edge select. Addresses 6 and 7 read 0.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, edge-select, enable and flag registers read 0x00. The output-data register reads 0xFF, except that bits set in `ANALOG_MASK` read 0.
- R2: For a pin in GPIO mode, a direction bit of 1 gives `pad_oe`=1 and `pad_out` equal to the output-data bit. A direction bit of 0 gives `pad_oe`=0.
- R3: For an input pin in GPIO mode, `pad_pull` equals the output-data bit. `pad_pull` is 0 whenever `pad_oe` is 1.
- R4: Writing the direction register never changes the stored output-data register.
- R5: Address 2 returns the pad level two clock edges after the pad changes, including on pins under alternate-function override. Writes to address 2 have no effect.
- R6: A flag bit sets when the synchronized level rises and its edge-select bit is 0, or falls and its edge-select bit is 1. The flag is readable after the third clock edge that follows the pad change.
- R7: Edge detection and flag setting work the same way when the pin is under alternate-function override.
- R8: When `alt_en[n]` is 1, `pad_oe[n]` and `pad_out[n]` follow `alt_oe[n]` and `alt_out[n]`, and `pad_pull[n]` is 0. The output-data and direction bits have no effect on these outputs.
- R9: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R10: `irq` is 1 exactly when some pin has both its flag bit and its enable bit set.
- R11: With `DEBUG_VARIANT`=1, bit 7 reads 0 in every register, and pin 7 drives `pad_oe`=0 and `pad_pull`=0.
- R12: With `DEBUG_VARIANT`=1 and `dbg_en`=1, pins 3:0 drive `pad_oe`, `pad_out` and `pad_pull` at 0, even under override. On pins 6:4 the direction bit has no effect. Once `dbg_en`=0, GPIO behaviour resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pull | output | 8 | Weak-pullup enables |
| alt_en | input | 8 | Per-pin peripheral override |
| alt_oe | input | 8 | Peripheral output enables |
| alt_out | input | 8 | Peripheral output values |
| dbg_en | input | 1 | Debug-port ownership (7-pin build only) |
| irq | output | 1 | Port interrupt request |

## Verification
The hardware set of an interrupt flag and a software clear of the flag register can land on the same clock edge. The bench provokes this by changing a pad level and timing a clearing write so that it commits on the edge where the detected edge is latched. It then expects the newly set bit to survive while other bits are cleared. Random traffic also mixes pad changes, flag writes and override toggling, and every read is compared against a bench register model.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter logic [7:0] ANALOG_MASK   = 8'h00,
  parameter bit         DEBUG_VARIANT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_out,
  output logic [7:0] pad_pull,
  input  logic [7:0] alt_en,
  input  logic [7:0] alt_oe,
  input  logic [7:0] alt_out,
  input  logic       dbg_en,
  output logic       irq
);
  localparam logic [7:0] PIN_MASK = DEBUG_VARIANT ? 8'h7F : 8'hFF;
  localparam logic [7:0] DBG_PINS = 8'h0F;
  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_IN = 3'd2,
                         A_FLAG = 3'd3, A_EN = 3'd4, A_SEL = 3'd5;

  logic [7:0] dir_q, out_q, sel_q, en_q, flag_q, s1_q, s2_q, prev_q;
  logic [7:0] hit, flag_n;
  logic       gpio_off, wr_flag;

  assign gpio_off = DEBUG_VARIANT && dbg_en;
  assign hit      = (s2_q ^ prev_q) & (s2_q ^ sel_q) & PIN_MASK;
  assign wr_flag  = bus_we && (bus_addr == A_FLAG);
  assign flag_n   = (wr_flag ? (flag_q & bus_wdata) : flag_q) | hit;
  assign irq      = |(flag_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 8'h00;
      out_q  <= ~ANALOG_MASK & PIN_MASK;
      sel_q  <= 8'h00;
      en_q   <= 8'h00;
      flag_q <= 8'h00;
      s1_q   <= 8'h00;
      s2_q   <= 8'h00;
      prev_q <= 8'h00;
    end else begin
      s1_q   <= pad_in & PIN_MASK;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      flag_q <= flag_n;
      if (bus_we) begin
        case (bus_addr)
          A_DIR:   dir_q <= bus_wdata & PIN_MASK;
          A_OUT:   out_q <= bus_wdata & PIN_MASK;
          A_EN:    en_q  <= bus_wdata & PIN_MASK;
          A_SEL:   sel_q <= bus_wdata & PIN_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_IN:    bus_rdata = s2_q;
      A_FLAG:  bus_rdata = flag_q;
      A_EN:    bus_rdata = en_q;
      A_SEL:   bus_rdata = sel_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (!PIN_MASK[i] || (gpio_off && DBG_PINS[i])) begin
        pad_oe[i] = 1'b0; pad_out[i] = 1'b0; pad_pull[i] = 1'b0;
      end else if (alt_en[i]) begin
        pad_oe[i] = alt_oe[i]; pad_out[i] = alt_out[i]; pad_pull[i] = 1'b0;
      end else if (gpio_off) begin
        pad_oe[i] = 1'b0; pad_out[i] = 1'b0; pad_pull[i] = 1'b0;
      end else begin
        pad_oe[i]   = dir_q[i];
        pad_out[i]  = out_q[i];
        pad_pull[i] = ~dir_q[i] & out_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter bit DEBUG_VARIANT = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_pull,
  input logic       dbg_en,
  input logic [7:0] dir_q,
  input logic [7:0] out_q,
  input logic [7:0] flag_q,
  input logic [7:0] s2_q,
  input logic [7:0] prev_q
);
  logic [7:0] clr;
  assign clr = (bus_we && bus_addr == 3'd3) ? ~bus_wdata : 8'h00;

  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q & ~$past(clr)) == 8'h00)); // R9
  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(flag_q) & flag_q & ~($past(s2_q) ^ $past(prev_q))) == 8'h00)); // R6
  AST_DIR_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> $stable(out_q)); // R4
  AST_PULL_NOT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull & pad_oe) == 8'h00)); // R3

  generate
    if (DEBUG_VARIANT) begin : g_var
      AST_BIT7_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[7] == 1'b0 && flag_q[7] == 1'b0 && dir_q[7] == 1'b0)); // R11
      AST_DEBUG_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en |-> (pad_oe[3:0] == 4'h0 && pad_pull[3:0] == 4'h0)); // R12
    end
  endgenerate
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.DEBUG_VARIANT(DEBUG_VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .pad_pull(pad_pull),
  .dbg_en(dbg_en), .dir_q(dir_q), .out_q(out_q), .flag_q(flag_q),
  .s2_q(s2_q), .prev_q(prev_q)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pad_in = 8'h00, alt_en = 8'h00, alt_oe = 8'h00, alt_out = 8'h00;
  logic       dbg = 1'b1;
  logic [7:0] rdata, oe, po, pu, rdata_v, oe_v, po_v, pu_v;
  logic       irq, irq_v;
  int checks = 0, fails = 0;

  localparam logic [7:0] AMASK = 8'h30;
  logic [7:0] m_dir, m_out, m_flag, m_en, m_sel;

  always #4 clk = ~clk;

  gpio_edge_port #(.ANALOG_MASK(AMASK), .DEBUG_VARIANT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in), .pad_oe(oe),
    .pad_out(po), .pad_pull(pu), .alt_en(alt_en), .alt_oe(alt_oe),
    .alt_out(alt_out), .dbg_en(1'b0), .irq(irq));

  gpio_edge_port #(.ANALOG_MASK(8'h00), .DEBUG_VARIANT(1'b1)) dut_v (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_v), .pad_in(pad_in), .pad_oe(oe_v),
    .pad_out(po_v), .pad_pull(pu_v), .alt_en(alt_en), .alt_oe(alt_oe),
    .alt_out(alt_out), .dbg_en(dbg), .irq(irq_v));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
    case (a)
      3'd0: m_dir = d;
      3'd1: m_out = d;
      3'd3: m_flag = m_flag & d;
      3'd4: m_en = d;
      3'd5: m_sel = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] dv);
    @(negedge clk); bus_addr = a; #1; d = rdata; dv = rdata_v;
  endtask

  function automatic logic [7:0] edges(input logic [7:0] o, input logic [7:0] n, input logic [7:0] s);
    return (o ^ n) & (n ^ s);
  endfunction

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk);
    m_flag = m_flag | edges(pad_in, v, m_sel);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_pads(input string tag);
    logic [7:0] eoe, eout, epu;
    #1;
    eoe  = (alt_en & alt_oe)  | (~alt_en & m_dir);
    eout = (alt_en & alt_out) | (~alt_en & m_out);
    epu  = ~alt_en & ~m_dir & m_out;
    chk({tag, " pad_oe"}, oe, eoe);
    chk({tag, " pad_out"}, po & oe, eout & eoe);
    chk({tag, " pad_pull"}, pu, epu);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, |(m_flag & m_en)});
  endtask

  task automatic chk_all_regs(input string tag);
    logic [7:0] d, dv;
    rd(3'd0, d, dv); chk({tag, " dir"}, d, m_dir);
    rd(3'd1, d, dv); chk({tag, " out"}, d, m_out);
    rd(3'd2, d, dv); chk({tag, " in"}, d, pad_in);
    rd(3'd3, d, dv); chk({tag, " flag"}, d, m_flag);
    rd(3'd4, d, dv); chk({tag, " en"}, d, m_en);
    rd(3'd5, d, dv); chk({tag, " sel"}, d, m_sel);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, dv;
    void'($urandom(32'h5eed_1234));
    m_dir = 8'h00; m_out = ~AMASK; m_flag = 8'h00; m_en = 8'h00; m_sel = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk_all_regs("R1 reset");
    rd(3'd1, d, dv); chk("R1 R11 variant out reset", dv, 8'h7F);
    chk_pads("R1 R3 reset pads");

    // R11 R12: variant with debug port active
    wr(3'd0, 8'hFF);
    rd(3'd0, d, dv); chk("R11 variant dir bit7 absent", dv, 8'h7F);
    #1; chk("R12 debug owns pins, dir ignored", oe_v, 8'h00);
    alt_en = 8'h11; alt_oe = 8'h11; alt_out = 8'h11;
    #1; chk("R12 debug blocks override on low pins", oe_v, 8'h10);
    alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
    @(negedge clk); dbg = 1'b0;
    #1; chk("R11 R12 gpio resumes", oe_v, 8'h7F);
    wr(3'd0, 8'h00);

    // R4: direction changes keep output data
    wr(3'd1, 8'hA5);
    wr(3'd0, 8'hF0); wr(3'd0, 8'h0F);
    rd(3'd1, d, dv); chk("R4 out kept over dir writes", d, 8'hA5);
    chk_pads("R2 R3 mixed dir");

    // R5: input register is read-only and follows pad
    wr(3'd2, 8'h3C);
    set_pad(8'h81);
    rd(3'd2, d, dv); chk("R5 input reflects pad, write ignored", d, 8'h81);
    chk("R11 variant input bit7 absent", dv, 8'h01);

    // R6 R9 R10: edges, clear, irq
    wr(3'd3, 8'h00); wr(3'd5, 8'hF0); wr(3'd4, 8'h03);
    set_pad(8'h40);
    rd(3'd3, d, dv); chk("R6 rise on sel0, fall on sel1", d, m_flag);
    chk_pads("R10 irq");
    wr(3'd3, 8'hFF);
    rd(3'd3, d, dv); chk("R9 writing ones keeps flags", d, m_flag);

    // R7 R8: override on pin 1
    alt_en = 8'h02; alt_oe = 8'h02; alt_out = 8'h00;
    wr(3'd3, 8'h00);
    set_pad(8'h42);
    rd(3'd3, d, dv); chk("R7 edge flagged under override", d, 8'h02);
    rd(3'd2, d, dv); chk("R5 input under override", d, 8'h42);
    wr(3'd1, 8'hFF);
    chk_pads("R8 override pads");

    // R9: set and clear in the same cycle (pin 0 rises, pin 1 cleared)
    @(negedge clk); pad_in = 8'h43;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h00;
    @(negedge clk); bus_we = 1'b0;
    m_flag = 8'h01;
    rd(3'd3, d, dv); chk("R9 set wins over clear", d, 8'h01);
    alt_en = 8'h00; alt_oe = 8'h00;

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: wr(3'($urandom_range(0, 5)), 8'($urandom));
        1: set_pad(8'($urandom));
        2: begin
             @(negedge clk);
             alt_en = 8'($urandom); alt_oe = 8'($urandom); alt_out = 8'($urandom);
             chk_pads("R2 R3 R8 R10 random pads");
           end
        3: chk_all_regs("R4 R5 R6 R9 random regs");
        default: wr(3'd3, 8'($urandom));
      endcase
    end
    chk_all_regs("R6 R9 final regs");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule